// File: doc/BRIEF.md
# Oscillator Clock-Enable Controller with Suspend Wake

This block sits between a free-running oscillator and the rest of a chip. It turns the oscillator's tick stream into a system clock-enable pulse. The pulse comes on every tick, or on every second, fourth or eighth tick. One 8-bit control register sets the rate, turns the oscillator path on or off, and can put it to sleep. The oscillator itself, its trimming, the USB transceiver and glitch-free clock switching are all outside the block. The divided clock is modelled as a one-cycle enable.

Setting the sleep bit stops the path. The path starts again when the USB bus signals a non-idle event such as resume, or when the VBUS level equals a configured polarity. Both wake inputs pass through a two-flop synchroniser in the always-on domain, so waking does not rely on the stopped path. The sleep bit clears itself on wake. A ready bit reports that the path has run long enough to settle. It counts a parameterised number of ticks after each start.

Top module: `osc_susp_ctrl`

## Requirements
- R1: After reset the control register reads 8'h80: enable bit 7 is 1, ready bit 6 is 0, sleep bit 5 is 0, and the divisor field in bits 1..0 is 00.
- R2: The divisor field sets how many oscillator ticks make up one clock-enable period: 00 gives 8, 01 gives 4, 10 gives 2 and 11 gives 1. `sysclk_en_o` is high for exactly one tick per period.
- R3: A divisor written in the middle of a period takes effect only after the current period ends. No period is ever shortened.
- R4: Writing 1 to bit 5 stops the path. No enable pulses follow, bit 5 reads 1 and ready reads 0. Writing 0 to bit 5 has no effect on sleep.
- R5: While asleep, a high level on `usb_resume_i` clears bit 5 on the third clock edge after it is applied. The path then runs again.
- R6: While asleep, the path wakes in the same way when `vbus_i` equals `vbus_pol_i`. It stays asleep while they differ, for either polarity setting.
- R7: Ready (bit 6) rises only after SETTLE_TICKS ticks have been counted while running. The count restarts after reset, after a wake and after a re-enable.
- R8: Bit 7 is a read/write enable. While it is 0, no enable pulses occur and ready reads 0.
- R9: Bits 4..2 always read 0, and writing ones to them changes nothing else.
- R10: Only cycles with `osc_tick_i` high advance the divider. With ticks on every other cycle the pulse rate halves, and with no ticks there are no pulses.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Always-on clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| osc_tick_i | input | 1 | Oscillator tick qualifier |
| we_i | input | 1 | Register write strobe |
| wdata_i | input | 8 | Register write data |
| rdata_o | output | 8 | Register read data |
| usb_resume_i | input | 1 | Asynchronous USB non-idle event |
| vbus_i | input | 1 | Asynchronous VBUS level |
| vbus_pol_i | input | 1 | VBUS wake polarity |
| sysclk_en_o | output | 1 | Divided clock-enable pulse |

## Verification
The divider is run with each of the four divisor codes under three tick patterns: ticks on every cycle, ticks on every other cycle, and no ticks. Pulses are counted over windows that hold a whole number of periods. This separates a swapped or reversed code table from a divider that ignores the tick qualifier. A divisor written mid-period is timed pulse to pulse, which shows whether the old period is completed or cut short. The wake paths are driven from both USB resume and VBUS, with matching and non-matching polarities, and the timing of the sleep-bit clear is checked against the synchroniser latency.

// File: rtl/osc_ctrl_pkg.sv
package osc_ctrl_pkg;
  localparam int REG_W    = 8;
  localparam int EN_BIT   = 7;
  localparam int RDY_BIT  = 6;
  localparam int SUSP_BIT = 5;
  localparam int DIV_W    = 2;
  localparam int PHASE_W  = 3;

  typedef enum logic [DIV_W-1:0] {
    DIV_8 = 2'b00,
    DIV_4 = 2'b01,
    DIV_2 = 2'b10,
    DIV_1 = 2'b11
  } div_sel_e;

  // last phase index of one enable period
  function automatic logic [PHASE_W-1:0] div_last(div_sel_e d);
    unique case (d)
      DIV_8:   div_last = 3'd7;
      DIV_4:   div_last = 3'd3;
      DIV_2:   div_last = 3'd1;
      default: div_last = 3'd0;
    endcase
  endfunction
endpackage

// File: rtl/sync_2ff.sv
module sync_2ff #(
  parameter int W = 1
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] s1_q, s2_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      s1_q <= '0;
      s2_q <= '0;
    end else begin
      s1_q <= d_i;
      s2_q <= s1_q;
    end
  end

  assign q_o = s2_q;
endmodule

// File: rtl/wake_detect.sv
module wake_detect (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic usb_resume_i,
  input  logic vbus_i,
  input  logic vbus_pol_i,
  output logic wake_o
);
  logic [1:0] raw, synced;

  assign raw = {vbus_i, usb_resume_i};

  sync_2ff #(.W(2)) u_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   (raw),
    .q_o   (synced)
  );

  assign wake_o = synced[0] | (synced[1] == vbus_pol_i);
endmodule

// File: rtl/settle_timer.sv
module settle_timer #(
  parameter int SETTLE_TICKS = 16
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic run_i,
  input  logic tick_i,
  output logic ready_o
);
  localparam int CW = $clog2(SETTLE_TICKS + 1);
  localparam logic [CW-1:0] LIMIT = CW'(SETTLE_TICKS);

  logic [CW-1:0] cnt_q;
  logic          done;

  assign done = (cnt_q == LIMIT);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)              cnt_q <= '0;
    else if (!run_i)          cnt_q <= '0;
    else if (tick_i && !done) cnt_q <= cnt_q + 1'b1;
  end

  assign ready_o = run_i & done;
endmodule

// File: rtl/tick_divider.sv
module tick_divider
  import osc_ctrl_pkg::*;
(
  input  logic     clk_i,
  input  logic     rst_ni,
  input  logic     run_i,
  input  logic     tick_i,
  input  div_sel_e div_i,
  output logic     en_o
);
  logic [PHASE_W-1:0] phase_q;
  div_sel_e           cur_q;
  logic               wrap;

  assign wrap = (phase_q == div_last(cur_q));

  // divisor is only reloaded at a period boundary or while stopped
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      phase_q <= '0;
      cur_q   <= DIV_8;
    end else if (!run_i) begin
      phase_q <= '0;
      cur_q   <= div_i;
    end else if (tick_i) begin
      if (wrap) begin
        phase_q <= '0;
        cur_q   <= div_i;
      end else begin
        phase_q <= phase_q + 1'b1;
      end
    end
  end

  assign en_o = run_i & tick_i & wrap;
endmodule

// File: rtl/osc_susp_ctrl.sv
module osc_susp_ctrl
  import osc_ctrl_pkg::*;
#(
  parameter int SETTLE_TICKS = 16
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       osc_tick_i,
  input  logic       we_i,
  input  logic [7:0] wdata_i,
  output logic [7:0] rdata_o,
  input  logic       usb_resume_i,
  input  logic       vbus_i,
  input  logic       vbus_pol_i,
  output logic       sysclk_en_o
);
  logic     en_q, susp_q, wake, run, ready;
  div_sel_e div_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      en_q  <= 1'b1;
      div_q <= DIV_8;
    end else if (we_i) begin
      en_q  <= wdata_i[EN_BIT];
      div_q <= div_sel_e'(wdata_i[DIV_W-1:0]);
    end
  end

  // set by write wins over a same-cycle wake
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                       susp_q <= 1'b0;
    else if (we_i && wdata_i[SUSP_BIT]) susp_q <= 1'b1;
    else if (wake)                     susp_q <= 1'b0;
  end

  assign run = en_q & ~susp_q;

  wake_detect u_wake (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .usb_resume_i(usb_resume_i),
    .vbus_i      (vbus_i),
    .vbus_pol_i  (vbus_pol_i),
    .wake_o      (wake)
  );

  settle_timer #(.SETTLE_TICKS(SETTLE_TICKS)) u_settle (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .run_i  (run),
    .tick_i (osc_tick_i),
    .ready_o(ready)
  );

  tick_divider u_div (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .run_i (run),
    .tick_i(osc_tick_i),
    .div_i (div_q),
    .en_o  (sysclk_en_o)
  );

  assign rdata_o = {en_q, ready, susp_q, 3'b000, div_q};
endmodule

// File: rtl/osc_susp_ctrl_chk.sv
module osc_susp_ctrl_chk (
  input logic       clk_i,
  input logic       rst_ni,
  input logic       we_i,
  input logic [7:0] wdata_i,
  input logic [7:0] rdata_o,
  input logic       usb_resume_i,
  input logic       sysclk_en_o
);
  logic [1:0] age_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)           age_q <= '0;
    else if (age_q != 2'd3) age_q <= age_q + 1'b1;
  end

  // R4
  susp_quiet_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rdata_o[5] |-> (!sysclk_en_o && !rdata_o[6]));

  // R4
  susp_set_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (we_i && wdata_i[5]) |=> rdata_o[5]);

  // R5
  usb_wake_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((age_q == 2'd3) && rdata_o[5] && $past(usb_resume_i, 2) && !(we_i && wdata_i[5]))
    |=> !rdata_o[5]);

  // R8
  off_quiet_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !rdata_o[7] |-> (!sysclk_en_o && !rdata_o[6]));

  // R8
  en_write_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    we_i |=> (rdata_o[7] == $past(wdata_i[7])));
endmodule

bind osc_susp_ctrl osc_susp_ctrl_chk u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .we_i        (we_i),
  .wdata_i     (wdata_i),
  .rdata_o     (rdata_o),
  .usb_resume_i(usb_resume_i),
  .sysclk_en_o (sysclk_en_o)
);

// File: tb/osc_susp_ctrl_bench.sv
`timescale 1ns/1ps
module osc_susp_ctrl_bench;
  localparam int SETTLE = 16;
  localparam int WD_CYCLES = 20000;
  // [10:9] tick mode (0 every cycle, 1 every other, 2 none), [8:7] code, [6:0] pulses in 64 cycles
  localparam logic [10:0] VEC [9] = '{
    {2'd0, 2'b00, 7'd8},  {2'd0, 2'b01, 7'd16}, {2'd0, 2'b10, 7'd32},
    {2'd0, 2'b11, 7'd64}, {2'd1, 2'b11, 7'd32}, {2'd1, 2'b10, 7'd16},
    {2'd1, 2'b01, 7'd8},  {2'd1, 2'b00, 7'd4},  {2'd2, 2'b11, 7'd0}
  };

  logic       clk = 1'b0, rst_ni = 1'b0, tick, we = 1'b0;
  logic [7:0] wdata = '0, rdata;
  logic       usb = 1'b0, vbus = 1'b0, vpol = 1'b1, sys_en;
  logic [1:0] tmode = 2'd0;
  int         n_chk = 0, n_fail = 0;
  bit         done = 1'b0;

  always #10 clk = ~clk;

  initial begin
    tick = 1'b1;
    forever begin
      @(posedge clk);
      #2;
      case (tmode)
        2'd0:    tick = 1'b1;
        2'd1:    tick = ~tick;
        default: tick = 1'b0;
      endcase
    end
  end

  osc_susp_ctrl #(.SETTLE_TICKS(SETTLE)) u_osc_susp_ctrl (
    .clk_i(clk), .rst_ni(rst_ni), .osc_tick_i(tick), .we_i(we), .wdata_i(wdata),
    .rdata_o(rdata), .usb_resume_i(usb), .vbus_i(vbus), .vbus_pol_i(vpol),
    .sysclk_en_o(sys_en)
  );

  task automatic chk(string req, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic step();
    @(negedge clk);
    #1;
  endtask

  task automatic steps(int n);
    for (int i = 0; i < n; i++) step();
  endtask

  task automatic wr(logic [7:0] d);
    @(negedge clk);
    we = 1'b1;
    wdata = d;
    @(negedge clk);
    we = 1'b0;
    #1;
  endtask

  task automatic count_pulses(int n, output int c);
    c = 0;
    for (int i = 0; i < n; i++) begin
      step();
      if (sys_en) c++;
    end
  endtask

  task automatic steps_to_ready(output int c);
    c = 0;
    while (!rdata[6] && c < 200) begin
      step();
      c++;
    end
  endtask

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
  endtask

  initial begin
    #(WD_CYCLES * 20);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
      summary();
      $finish;
    end
  end

  initial begin
    int c, k;
    steps(3);
    @(negedge clk);
    rst_ni = 1'b1;
    #1;
    chk("R1 reset value", rdata, 8'h80);
    steps_to_ready(c);
    chk("R7 settle after reset", c, SETTLE);

    // R2 / R10 divisor table under several tick patterns
    foreach (VEC[i]) begin
      tmode = VEC[i][10:9];
      wr(8'h80 | {6'b0, VEC[i][8:7]});
      steps(24);
      count_pulses(64, c);
      chk(VEC[i][10:9] == 2'd0 ? "R2 divide" : "R10 tick gate", c, int'(VEC[i][6:0]));
    end
    tmode = 2'd0;

    // R3 divisor change mid-period
    wr(8'h80);
    steps(24);
    c = 0;
    while (!sys_en && c < 20) begin step(); c++; end
    k = 0;
    for (int j = 1; j <= 20; j++) begin
      step();
      if (j == 3) begin we = 1'b1; wdata = 8'h83; end
      if (j == 4) we = 1'b0;
      if (sys_en) begin k = j; break; end
    end
    chk("R3 old period kept", k, 8);
    step();
    chk("R3 new period", sys_en, 1);

    // R9 unused bits
    wr(8'h9F);
    chk("R9 unused read zero", rdata, 8'hC3);

    // R4 / R5 suspend and USB wake
    wr(8'hA3);
    chk("R4 suspend read", rdata, 8'hA3);
    count_pulses(20, c);
    chk("R4 no pulses asleep", c, 0);
    wr(8'h83);
    chk("R4 zero write ignored", rdata[5], 1);
    usb = 1'b1;
    steps(2);
    chk("R5 sync latency", rdata[5], 1);
    step();
    chk("R5 usb wake clears", rdata[5], 0);
    usb = 1'b0;
    steps_to_ready(c);
    chk("R7 settle after wake", c, SETTLE);
    count_pulses(16, c);
    chk("R5 pulses resume", c, 16);

    // R6 VBUS wake, both polarities
    wr(8'hA3);
    steps(6);
    chk("R6 mismatch stays asleep", rdata[5], 1);
    vbus = 1'b1;
    steps(3);
    chk("R6 match high wakes", rdata[5], 0);
    vpol = 1'b0;
    steps(3);
    wr(8'hA3);
    steps(6);
    chk("R6 mismatch low pol", rdata[5], 1);
    vbus = 1'b0;
    steps(3);
    chk("R6 match low wakes", rdata[5], 0);
    vpol = 1'b1;
    steps(3);

    // R8 enable bit
    wr(8'h03);
    chk("R8 disabled read", rdata, 8'h03);
    count_pulses(20, c);
    chk("R8 no pulses disabled", c, 0);
    wr(8'h83);
    steps_to_ready(c);
    chk("R7 settle after enable", c, SETTLE);

    done = 1'b1;
    summary();
    $finish;
  end
endmodule